// File: doc/BRIEF.md
# Banked Bit-Addressable Data Memory

This block is the 128-byte internal scratch memory of a small control-oriented processor. The same byte array is reachable in three byte-wide ways and one bit-wide way. A direct access names the byte outright. A register access names one of eight working registers in the active bank. An indirect access uses working register 0 or 1 of the active bank as a pointer. A bit access reads or modifies one bit of a sixteen-byte bit field.

Two bank-select inputs choose which group of eight bytes at the bottom of the array acts as the working registers. The surrounding core drives them, so switching banks needs no data movement. Bit numbers whose top bit is set belong to the special-register space, which is outside this block. Those requests are handed out unchanged on a forwarding port, and the bit read back from that port is returned on the bit-read output. Read data is combinational from the current contents. Writes land on the next rising clock.

Top module: `bank_bit_ram`

## Requirements
- R1: While `rst_n` is low, every byte is cleared to 00H, so after reset every readable byte returns 00H.
- R2: Byte mode code 0 (direct) reads and, with `byte_we` high, writes the byte at `byte_addr` when that address is 00H to 7FH.
- R3: Byte mode code 1 (register) uses address `bank_sel*8 + reg_idx`. With bank 3 and index 7 the byte at 1FH is accessed.
- R4: Byte mode codes 2 and 3 (indirect) use as the address the current contents of the byte at `bank_sel*8 + ptr_sel`.
- R5: If a direct or indirect address is 80H or above, `byte_oor` is high during that request, `byte_rdata` is 00H, and a write leaves every byte unchanged.
- R6: A bit number n below 80H selects bit n mod 8 of byte 20H + n/8. `bit_rdata` returns that bit's value before the operation.
- R7: Bit operation codes are 0 read, 1 set, 2 clear, 3 complement and 4 write `bit_wval`. Codes 5 to 7 change nothing. A modifying operation changes only the addressed bit and takes effect at the next clock.
- R8: A bit number of 80H or above raises `sfr_req` and presents `bit_op`, `bit_addr` and `bit_wval` on `sfr_op`, `sfr_addr` and `sfr_wval`. `bit_rdata` then equals `sfr_rdata`, and no RAM byte changes.
- R9: Reads in a cycle return the contents before that cycle's writes. `byte_rdata` and `bit_rdata` are 00H and 0 when their request is low.
- R10: If a byte write and a modifying bit operation hit the same byte in one cycle, the byte write alone takes effect.
- R11: A change of `bank_sel` takes effect on the very next access, without moving any data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Active working-register bank |
| byte_req | input | 1 | Byte access request |
| byte_we | input | 1 | Byte write enable |
| byte_mode | input | 2 | 0 direct, 1 register, 2/3 indirect |
| byte_addr | input | 8 | Direct byte address |
| reg_idx | input | 3 | Working register index |
| ptr_sel | input | 1 | Pointer register 0 or 1 for indirect |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data |
| byte_oor | output | 1 | Byte address out of range |
| bit_req | input | 1 | Bit access request |
| bit_op | input | 3 | Bit operation code |
| bit_addr | input | 8 | Bit number |
| bit_wval | input | 1 | Value for the bit-write operation |
| bit_rdata | output | 1 | Bit read value |
| sfr_req | output | 1 | Forwarded special-register bit request |
| sfr_op | output | 3 | Forwarded operation code |
| sfr_addr | output | 8 | Forwarded bit number |
| sfr_wval | output | 1 | Forwarded write value |
| sfr_rdata | input | 1 | Bit value returned by the special-register side |

## Verification
The bound checker watches every cycle for the effects that can be stated locally. A set or clear must land on the addressed bit and leave its seven neighbours alone. A register-mode write must land at bank times eight plus the index. A forwarded bit request must leave the RAM untouched, and an out-of-range byte request must read as zero. Other behaviour depends on history and shows only in the bench's scenarios, where a behavioural model is compared on every clock. This covers pointer-chained indirect addresses, bank switches seen on the next access, read-before-write timing, write-versus-bit collision priority and the ignored operation codes.

// File: rtl/bank_bit_ram.sv
module bank_bit_ram #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_sel,
  input  logic          byte_req,
  input  logic          byte_we,
  input  logic [1:0]    byte_mode,
  input  logic [7:0]    byte_addr,
  input  logic [2:0]    reg_idx,
  input  logic          ptr_sel,
  input  logic [DW-1:0] byte_wdata,
  output logic [DW-1:0] byte_rdata,
  output logic          byte_oor,
  input  logic          bit_req,
  input  logic [2:0]    bit_op,
  input  logic [7:0]    bit_addr,
  input  logic          bit_wval,
  output logic          bit_rdata,
  output logic          sfr_req,
  output logic [2:0]    sfr_op,
  output logic [7:0]    sfr_addr,
  output logic          sfr_wval,
  input  logic          sfr_rdata
);
  localparam int DEPTH = 128;
  localparam logic [2:0] BIT_BASE_HI = 3'b010;

  logic [DW-1:0] mem [DEPTH];

  logic [6:0] reg_addr, ptr_addr, bit_byte;
  logic [7:0] ptr_val, eaddr;
  logic       byte_wr, bit_int, bit_mod, bit_wr, cur_bit, new_bit;

  assign reg_addr = {2'b00, bank_sel, reg_idx};
  assign ptr_addr = {2'b00, bank_sel, 2'b00, ptr_sel};
  assign ptr_val  = mem[ptr_addr];
  assign eaddr    = byte_mode[1] ? ptr_val : (byte_mode[0] ? {1'b0, reg_addr} : byte_addr);

  assign byte_oor   = byte_req && eaddr[7];
  assign byte_rdata = (byte_req && !eaddr[7]) ? mem[eaddr[6:0]] : '0;
  assign byte_wr    = byte_req && byte_we && !eaddr[7];

  assign bit_byte = {BIT_BASE_HI, bit_addr[6:3]};
  assign bit_int  = bit_req && !bit_addr[7];
  assign cur_bit  = mem[bit_byte][bit_addr[2:0]];

  always_comb begin
    bit_mod = 1'b1;
    new_bit = cur_bit;
    case (bit_op)
      3'd1:    new_bit = 1'b1;
      3'd2:    new_bit = 1'b0;
      3'd3:    new_bit = ~cur_bit;
      3'd4:    new_bit = bit_wval;
      default: bit_mod = 1'b0;
    endcase
  end

  assign bit_wr    = bit_int && bit_mod && !(byte_wr && eaddr[6:0] == bit_byte);
  assign bit_rdata = bit_req && (bit_addr[7] ? sfr_rdata : cur_bit);

  assign sfr_req  = bit_req && bit_addr[7];
  assign sfr_op   = bit_op;
  assign sfr_addr = bit_addr;
  assign sfr_wval = bit_wval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (byte_wr) mem[eaddr[6:0]] <= byte_wdata;
      if (bit_wr)  mem[bit_byte][bit_addr[2:0]] <= new_bit;
    end
  end
endmodule

// File: rtl/bank_bit_ram_chk.sv
module bank_bit_ram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bank_sel,
  input logic       byte_req,
  input logic       byte_we,
  input logic [1:0] byte_mode,
  input logic [2:0] reg_idx,
  input logic [7:0] byte_wdata,
  input logic [7:0] byte_rdata,
  input logic       byte_oor,
  input logic       bit_req,
  input logic [2:0] bit_op,
  input logic [7:0] bit_addr,
  input logic       sfr_req,
  input logic [7:0] mem [128]
);
  logic [6:0] ra_q, bb_q;
  logic [2:0] bp_q;
  logic [7:0] wd_q, ob_q;
  logic [6:0] bb_now;

  assign bb_now = {3'b010, bit_addr[6:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra_q <= '0; bb_q <= 7'h20; bp_q <= '0; wd_q <= '0; ob_q <= '0;
    end else begin
      ra_q <= {2'b00, bank_sel, reg_idx};
      wd_q <= byte_wdata;
      bb_q <= bb_now;
      bp_q <= bit_addr[2:0];
      ob_q <= mem[bb_now];
    end
  end

  // R3
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && byte_we && byte_mode == 2'b01 && !bit_req |=> mem[ra_q] == wd_q);

  // R7
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && !bit_addr[7] && bit_op == 3'd1 && !byte_req |=> mem[bb_q][bp_q]);

  // R7
  bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && !bit_addr[7] && bit_op == 3'd2 && !byte_req |=> !mem[bb_q][bp_q]);

  // R7
  bit_neighbours_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && !bit_addr[7] && !byte_req |=> ((mem[bb_q] ^ ob_q) & ~(8'h01 << bp_q)) == 8'h00);

  // R8
  sfr_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && bit_addr[7] && !byte_req |=> mem[bb_q] == ob_q);

  // R8
  sfr_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_req |-> bit_req);

  // R5
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_oor |-> byte_rdata == 8'h00);
endmodule

bind bank_bit_ram bank_bit_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .byte_req(byte_req),
  .byte_we(byte_we), .byte_mode(byte_mode), .reg_idx(reg_idx),
  .byte_wdata(byte_wdata), .byte_rdata(byte_rdata), .byte_oor(byte_oor),
  .bit_req(bit_req), .bit_op(bit_op), .bit_addr(bit_addr), .sfr_req(sfr_req),
  .mem(mem)
);

// File: tb/bank_bit_ram_tb.sv
module bank_bit_ram_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic byte_req = 0, byte_we = 0, ptr_sel = 0;
  logic [1:0] byte_mode = '0;
  logic [7:0] byte_addr = '0, byte_wdata = '0, byte_rdata;
  logic [2:0] reg_idx = '0, bit_op = '0, sfr_op;
  logic byte_oor, bit_req = 0, bit_wval = 0, bit_rdata, sfr_req, sfr_wval, sfr_rdata = 0;
  logic [7:0] bit_addr = '0, sfr_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";
  logic [7:0] ref_mem [128];

  always #4 clk = ~clk;

  bank_bit_ram u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .byte_req(byte_req),
    .byte_we(byte_we), .byte_mode(byte_mode), .byte_addr(byte_addr),
    .reg_idx(reg_idx), .ptr_sel(ptr_sel), .byte_wdata(byte_wdata),
    .byte_rdata(byte_rdata), .byte_oor(byte_oor), .bit_req(bit_req),
    .bit_op(bit_op), .bit_addr(bit_addr), .bit_wval(bit_wval),
    .bit_rdata(bit_rdata), .sfr_req(sfr_req), .sfr_op(sfr_op),
    .sfr_addr(sfr_addr), .sfr_wval(sfr_wval), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_ea();
    if (byte_mode[1]) return int'(ref_mem[bank_sel * 8 + ptr_sel]);
    if (byte_mode[0]) return bank_sel * 8 + reg_idx;
    return int'(byte_addr);
  endfunction

  task automatic compare();
    int ea = ref_ea();
    logic [7:0] erd = (byte_req && ea < 128) ? ref_mem[ea] : 8'h00;
    logic eb = 1'b0;
    chk(byte_rdata == erd, "byte_rdata (R2/R3/R4/R9)", byte_rdata, erd);
    chk(byte_oor == (byte_req && ea >= 128), "byte_oor R5", byte_oor, byte_req && ea >= 128);
    if (bit_req) eb = (bit_addr >= 128) ? sfr_rdata : ref_mem[32 + bit_addr / 8][bit_addr % 8];
    chk(bit_rdata == eb, "bit_rdata R6", bit_rdata, eb);
    chk(sfr_req == (bit_req && bit_addr >= 128), "sfr_req R8", sfr_req, bit_req && bit_addr >= 128);
    if (sfr_req)
      chk(sfr_op == bit_op && sfr_addr == bit_addr && sfr_wval == bit_wval, "sfr fields R8",
          {sfr_op, sfr_addr, sfr_wval}, {bit_op, bit_addr, bit_wval});
  endtask

  task automatic update();
    int ea = ref_ea();
    int bw = -1;
    int bi;
    logic cur;
    if (byte_req && byte_we && ea < 128) begin ref_mem[ea] = byte_wdata; bw = ea; end
    if (bit_req && bit_addr < 128 && bit_op >= 1 && bit_op <= 4) begin
      bi = 32 + bit_addr / 8;
      if (bi != bw) begin
        cur = ref_mem[bi][bit_addr % 8];
        case (bit_op)
          3'd1: cur = 1'b1;
          3'd2: cur = 1'b0;
          3'd3: cur = ~cur;
          default: cur = bit_wval;
        endcase
        ref_mem[bi][bit_addr % 8] = cur;
      end
    end
  endtask

  task automatic cyc();
    #2 compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    byte_req = 0; byte_we = 0; bit_req = 0; bit_op = 0;
  endtask

  task automatic bacc(input logic [1:0] m, input logic [7:0] a, input logic [2:0] ri,
                      input logic p, input logic we, input logic [7:0] d);
    byte_req = 1; byte_mode = m; byte_addr = a; reg_idx = ri; ptr_sel = p;
    byte_we = we; byte_wdata = d;
  endtask

  task automatic bop(input logic [2:0] op, input logic [7:0] a, input logic v);
    bit_req = 1; bit_op = op; bit_addr = a; bit_wval = v;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    for (int a = 0; a < 128; a++) begin bacc(2'd0, 8'(a), 3'd0, 1'b0, 1'b0, 8'h00); cyc(); end
    idle();

    tag = "R2";
    bacc(2'd0, 8'h45, 0, 0, 1, 8'h3C); cyc();
    bacc(2'd0, 8'h45, 0, 0, 0, 8'h00); cyc();
    chk(byte_rdata == 8'h3C, "direct readback R2", byte_rdata, 8'h3C);

    tag = "R3";
    bacc(2'd0, 8'h1F, 0, 0, 1, 8'hA5); cyc();
    bank_sel = 2'd3; bacc(2'd1, 8'h00, 3'd7, 0, 0, 8'h00); #1;
    chk(byte_rdata == 8'hA5, "bank3 reg7 is 1FH R3", byte_rdata, 8'hA5); cyc();

    tag = "R11";
    bank_sel = 2'd0; bacc(2'd1, 8'h00, 3'd7, 0, 1, 8'h77); cyc();
    bank_sel = 2'd3; bacc(2'd1, 8'h00, 3'd7, 0, 0, 8'h00); #1;
    chk(byte_rdata == 8'hA5, "bank switch no copy R11", byte_rdata, 8'hA5); cyc();

    tag = "R4";
    bank_sel = 2'd2; bacc(2'd1, 8'h00, 3'd1, 0, 1, 8'h40); cyc();
    bacc(2'd2, 8'h00, 0, 1, 1, 8'hC3); cyc();
    bacc(2'd0, 8'h40, 0, 0, 0, 8'h00); #1;
    chk(byte_rdata == 8'hC3, "indirect via R1 R4", byte_rdata, 8'hC3); cyc();

    tag = "R5";
    bacc(2'd0, 8'h90, 0, 0, 1, 8'hEE); cyc();
    bacc(2'd1, 8'h00, 3'd0, 0, 1, 8'h85); cyc();
    bacc(2'd3, 8'h00, 0, 0, 1, 8'h11); #1;
    chk(byte_oor == 1'b1, "indirect oor R5", byte_oor, 1); cyc();
    for (int a = 0; a < 128; a++) begin bacc(2'd0, 8'(a), 0, 0, 0, 8'h00); cyc(); end

    tag = "R9";
    bacc(2'd0, 8'h50, 0, 0, 1, 8'h5A); #1;
    chk(byte_rdata == 8'h00, "read before write R9", byte_rdata, 8'h00); cyc();
    idle(); bop(3'd1, 8'h0B, 0); #1;
    chk(bit_rdata == 1'b0, "bit old value R9", bit_rdata, 0); cyc();
    idle(); cyc();

    tag = "R7";
    for (int op = 0; op < 8; op++) begin
      idle(); bop(3'(op), 8'h7D, 1'b1); cyc();
      idle(); bop(3'd3, 8'h02, 1'b0); cyc();
      idle(); bop(3'd4, 8'h7F, op[0]); cyc();
    end
    idle(); bacc(2'd0, 8'h2F, 0, 0, 0, 8'h00); cyc();

    tag = "R10";
    idle(); bacc(2'd0, 8'h21, 0, 0, 1, 8'h0F); bop(3'd1, 8'h0F, 0); cyc();
    idle(); bacc(2'd0, 8'h21, 0, 0, 0, 8'h00); #1;
    chk(byte_rdata == 8'h0F, "byte write wins R10", byte_rdata, 8'h0F); cyc();

    tag = "R8";
    idle(); sfr_rdata = 1; bop(3'd3, 8'hE3, 1); cyc();
    sfr_rdata = 0; bop(3'd1, 8'hA0, 0); cyc();

    tag = "R6";
    for (int n = 0; n < 3000; n++) begin
      idle();
      bank_sel = 2'($urandom);
      sfr_rdata = 1'($urandom);
      if ($urandom % 4 != 0)
        bacc(2'($urandom), ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 64),
             3'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
      if ($urandom % 3 != 0)
        bop(3'($urandom), ($urandom % 6 == 0) ? 8'($urandom) : 8'($urandom % 128), 1'($urandom));
      cyc();
    end
    idle();
    for (int a = 0; a < 128; a++) begin bacc(2'd0, 8'(a), 0, 0, 0, 8'h00); cyc(); end
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=%0d exp=done", n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule